// File: doc/BRIEF.md
# Right Shifter with Carry-Out

This combinational unit shifts a 32-bit operand to the right, either logically or arithmetically, and also produces the carry flag that the shift would set in a RISC datapath. It sits between the operand read port and the ALU. It takes an 8-bit shift amount that comes from one of two places: a constant encoded in the instruction, or the low byte of a register.

The two sources read a zero amount differently. An instruction-encoded zero stands for a shift of 32. A register-supplied zero is a true no-op, so the operand and the incoming carry pass through untouched. Amounts above 32 are legal when they come from a register and must saturate correctly.

Top module: `rshift_carry`

## Requirements
- R1: When `amt_is_imm` is 1 and `shamt` is 0, the unit behaves exactly as for an effective amount of 32, for both operations (`op_arith` 0 = logical, 1 = arithmetic).
- R2: When `amt_is_imm` is 0 and `shamt` is 0, `result` equals `opnd` and `carry_out` equals `carry_in`, for both operations.
- R3: A logical shift by 1 to 31 gives `opnd` shifted right with zeros in the vacated high bits, and `carry_out` equals `opnd[amount-1]`.
- R4: A logical shift by exactly 32 gives `result` 0 and `carry_out` equal to `opnd[31]`.
- R5: A logical shift by 33 to 255 gives `result` 0 and `carry_out` 0.
- R6: An arithmetic shift by 1 to 31 fills the vacated high bits with `opnd[31]`, and `carry_out` equals `opnd[amount-1]`.
- R7: An arithmetic shift by 32 to 255 sets every `result` bit and `carry_out` to `opnd[31]`.
- R8: A nonzero amount gives the same outputs whether `amt_is_imm` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd | input | 32 | Operand to shift |
| shamt | input | 8 | Shift amount |
| carry_in | input | 1 | Current carry flag |
| amt_is_imm | input | 1 | 1: amount from instruction field, 0: from register |
| op_arith | input | 1 | 0: logical right, 1: arithmetic right |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Shifter carry flag |

## Verification
The bench drives the amount boundaries 0, 1, 31, 32, 33 and 255 from both sources, using operands with the sign bit set and clear. A design that treats an instruction zero as a no-op would return the operand where zero or all-sign bits are expected. A design that uses the carry rule for 32 on larger logical shifts would leak `opnd[31]` into the carry at 33 and above. A design that drops the sign fill at large arithmetic amounts would return zero for negative operands. Random operands and amounts are then compared against a bit-by-bit model, which catches off-by-one carry selection.

// File: rtl/rshift_carry.sv
module rshift_carry #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic [AMT_W-1:0] shamt,
  input  logic             carry_in,
  input  logic             amt_is_imm,
  input  logic             op_arith,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int EW = AMT_W + 1;
  localparam logic [EW-1:0] FULL = EW'(WIDTH);

  logic [EW-1:0]    eff;
  logic             fill;
  logic [WIDTH-1:0] lost;

  assign eff  = (amt_is_imm && shamt == '0) ? FULL : {1'b0, shamt};
  assign fill = op_arith & opnd[WIDTH-1];
  assign lost = opnd >> (eff - EW'(1));

  always_comb begin
    if (eff == '0) begin
      result    = opnd;
      carry_out = carry_in;
    end else if (eff < FULL) begin
      result    = op_arith ? WIDTH'($signed(opnd) >>> eff) : (opnd >> eff);
      carry_out = lost[0];
    end else if (eff == FULL) begin
      result    = {WIDTH{fill}};
      carry_out = opnd[WIDTH-1];
    end else begin
      result    = {WIDTH{fill}};
      carry_out = fill;
    end
  end

  always_comb begin
    if (!$isunknown({opnd, shamt, carry_in, amt_is_imm, op_arith})) begin
      // R2
      reg_zero_pass_chk: assert (!(!amt_is_imm && shamt == '0) ||
                                 (result == opnd && carry_out == carry_in));
      // R5
      lsr_big_clear_chk: assert (!(!op_arith && !amt_is_imm && shamt > AMT_W'(WIDTH)) ||
                                 (result == '0 && !carry_out));
      // R7
      asr_big_sign_chk: assert (!(op_arith && (shamt >= AMT_W'(WIDTH) || (amt_is_imm && shamt == '0))) ||
                                (($countones(result) == 0 || $countones(result) == WIDTH) &&
                                 carry_out == result[0] && result[0] == opnd[WIDTH-1]));
      // R4
      lsr_full_chk: assert (!(!op_arith && amt_is_imm && shamt == '0) ||
                            (result == '0 && carry_out == opnd[WIDTH-1]));
      // R3
      lsr_top_zero_chk: assert (!(!op_arith && shamt != '0) || !result[WIDTH-1]);
    end
  end
endmodule

// File: tb/test_rshift_carry.sv
module test_rshift_carry;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] opnd;
  logic [7:0]  shamt;
  logic        carry_in, amt_is_imm, op_arith;
  logic [31:0] result;
  logic        carry_out;

  int tests = 0;
  int fails = 0;

  rshift_carry i_rshift_carry (
    .opnd(opnd), .shamt(shamt), .carry_in(carry_in),
    .amt_is_imm(amt_is_imm), .op_arith(op_arith),
    .result(result), .carry_out(carry_out)
  );

  // {opnd, shamt, cin, imm, arith, exp_result, exp_carry, req}
  localparam int NV = 15;
  localparam logic [83:0] VEC [NV] = '{
    {32'h80000001, 8'd0,   1'b1, 1'b1, 1'b0, 32'h00000000, 1'b1, 8'd1},
    {32'h7FFFFFFF, 8'd0,   1'b1, 1'b0, 1'b0, 32'h7FFFFFFF, 1'b1, 8'd2},
    {32'h80000000, 8'd0,   1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 1'b1, 8'd1},
    {32'h12345678, 8'd0,   1'b1, 1'b0, 1'b1, 32'h12345678, 1'b1, 8'd2},
    {32'h00000003, 8'd1,   1'b0, 1'b0, 1'b0, 32'h00000001, 1'b1, 8'd3},
    {32'h80000000, 8'd31,  1'b0, 1'b0, 1'b0, 32'h00000001, 1'b0, 8'd3},
    {32'hC0000000, 8'd31,  1'b0, 1'b1, 1'b0, 32'h00000001, 1'b1, 8'd8},
    {32'h80000000, 8'd31,  1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b0, 8'd6},
    {32'h80000000, 8'd32,  1'b0, 1'b0, 1'b0, 32'h00000000, 1'b1, 8'd4},
    {32'hFFFFFFFF, 8'd33,  1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 8'd5},
    {32'hFFFFFFFF, 8'd255, 1'b1, 1'b0, 1'b0, 32'h00000000, 1'b0, 8'd5},
    {32'h80000000, 8'd33,  1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b1, 8'd7},
    {32'h7FFFFFFF, 8'd255, 1'b1, 1'b0, 1'b1, 32'h00000000, 1'b0, 8'd7},
    {32'hF0000000, 8'd4,   1'b1, 1'b0, 1'b1, 32'hFF000000, 1'b0, 8'd6},
    {32'h00000010, 8'd5,   1'b0, 1'b0, 1'b0, 32'h00000000, 1'b1, 8'd3}
  };

  function automatic logic [32:0] model(input logic [31:0] v, input logic [7:0] a,
                                        input logic ci, input logic im, input logic ar);
    int e;
    logic f;
    logic [31:0] r;
    logic c;
    e = (im && a == 0) ? 32 : int'(a);
    f = ar & v[31];
    for (int i = 0; i < 32; i++) r[i] = (i + e < 32) ? v[i + e] : f;
    if (e == 0)       c = ci;
    else if (e <= 32) c = v[e - 1];
    else              c = f;
    return {r, c};
  endfunction

  task automatic apply(input logic [31:0] v, input logic [7:0] a, input logic ci,
                       input logic im, input logic ar, input logic [31:0] er,
                       input logic ec, input string req);
    @(posedge clk);
    opnd = v; shamt = a; carry_in = ci; amt_is_imm = im; op_arith = ar;
    #5;
    tests++;
    if (result !== er || carry_out !== ec) begin
      fails++;
      $display("FAIL %s: opnd=%h amt=%0d imm=%0b arith=%0b got %h/%0b expected %h/%0b",
               req, v, a, im, ar, result, carry_out, er, ec);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [32:0] m;
    opnd = '0; shamt = '0; carry_in = 1'b0; amt_is_imm = 1'b0; op_arith = 1'b0;
    // idle inputs, R2
    apply(32'h0, 8'd0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "R2");
    for (int k = 0; k < NV; k++)
      apply(VEC[k][83:52], VEC[k][51:44], VEC[k][43], VEC[k][42], VEC[k][41],
            VEC[k][40:9], VEC[k][8], $sformatf("R%0d", VEC[k][7:0]));
    // R8: nonzero amounts agree across sources
    for (int a = 1; a < 256; a += 17) begin
      m = model(32'hA5C3_0F96, 8'(a), 1'b1, 1'b0, 1'b1);
      apply(32'hA5C3_0F96, 8'(a), 1'b1, 1'b1, 1'b1, m[32:1], m[0], "R8");
    end
    // R1: instruction zero vs register 32
    for (int ar = 0; ar < 2; ar++) begin
      m = model(32'h9000_0005, 8'd32, 1'b0, 1'b0, ar[0]);
      apply(32'h9000_0005, 8'd0, 1'b0, 1'b1, ar[0], m[32:1], m[0], "R1");
    end
    // R3 R5 R6 R7: random sweep
    for (int n = 0; n < 400; n++) begin
      logic [31:0] v;
      logic [7:0]  a;
      logic ci, im, ar;
      v = $urandom; a = 8'($urandom); ci = 1'($urandom); im = 1'($urandom); ar = 1'($urandom);
      if (n % 4 == 0) a = 8'($urandom_range(0, 40));
      m = model(v, a, ci, im, ar);
      apply(v, a, ci, im, ar, m[32:1], m[0], ar ? "R6/R7" : "R3/R5");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule